// File: doc/BRIEF.md
# Triple-Redundant Press Counter with Feedback Voting

This block counts presses of a single push-button and keeps its whole state in three redundant copies. Each copy holds a two-stage edge detector and a small wrap-around counter. Every register bit is reloaded from a bitwise majority of the three copies, not from its own raw value. A single upset in one copy is therefore outvoted at once and cleared on the following clock edge. The clock, the synchronous reset and the button are shared by all three copies. The three count buses are brought out separately and are not reduced to one, so a later stage can place its own vote.

For verification, each copy has an injection enable and a mask. While the enable is high, the mask is XORed into that copy's next register value at the clock edge. A mismatch flag reports any cycle in which the raw register copies differ before voting. The majority can be built as a sum of products or as a compare-and-select form; a parameter picks the variant. The counter width is also a parameter.

Top module: `tmr_counter_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, every copy clears its counter and both edge stages, so all three count buses read 0 after that edge.
- R2: Reset wins over an increment: when `rst` is high at the edge where an increment would take effect, the counts read 0 after that edge and not 1.
- R3: Suppose `btn` is first sampled high at edge E after having been low. The counts rise by exactly one after edge E+1. Holding `btn` high for further cycles adds nothing more.
- R4: With `CNT_W`=2, an increment from the count 3 gives 0.
- R5: All three buses `cnt_a`, `cnt_b`, `cnt_c` always carry the same value, which is the fault-free count. This holds even when a fault is injected into one copy. The state bits of one copy are laid out as follows: bit 0 is the first edge stage, bit 1 is the second edge stage, and bits 2 and up hold the count. Copy k uses bits [k*ST_W +: ST_W] of `inj_mask`.
- R6: If exactly one copy k has `inj_en[k]` high at an edge with a nonzero mask slice, `mismatch` is high in the cycle after that edge.
- R7: After an edge at which `inj_en` is all zero, the raw copies agree and `mismatch` is low.
- R8: An injection enable with an all-zero mask has no effect: the counts are unchanged and `mismatch` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all copies |
| rst | input | 1 | Synchronous reset, active high |
| btn | input | 1 | Push-button level |
| inj_en | input | 3 | Per-copy fault injection enable |
| inj_mask | input | 3*(CNT_W+2) | Per-copy XOR masks, copy k at [k*ST_W +: ST_W] |
| cnt_a | output | CNT_W | Voted count of copy 0 |
| cnt_b | output | CNT_W | Voted count of copy 1 |
| cnt_c | output | CNT_W | Voted count of copy 2 |
| mismatch | output | 1 | Raw register copies disagree this cycle |

## Verification
The bench builds the block with `CNT_W`=2 and the sum-of-products voter. With the narrow width, a few presses are enough to reach the wrap from 3 to 0, and reset-over-increment can be set up in a handful of cycles. Single-copy faults are injected with every mask value up to 15, so every edge-stage bit and count bit of each copy is corrupted at some point. This includes faults that land on the very edge where an increment pulse is consumed.

// File: rtl/tmr_cnt_pkg.sv
package tmr_cnt_pkg;
   localparam int unsigned N_COPIES  = 3;
   localparam int unsigned EDGE_BITS = 2;

   typedef enum logic {
      VOTE_SOP = 1'b0,
      VOTE_MUX = 1'b1
   } vote_style_e;
endpackage

// File: rtl/tmr_maj_voter.sv
module tmr_maj_voter
   import tmr_cnt_pkg::*;
#(
   parameter int unsigned W     = 4,
   parameter vote_style_e STYLE = VOTE_SOP
) (
   input  logic [W-1:0] in_a,
   input  logic [W-1:0] in_b,
   input  logic [W-1:0] in_c,
   output logic [W-1:0] voted
);
   if (W < 1) begin : g_bad_w
      $error("tmr_maj_voter: W must be at least 1");
   end

   if (STYLE == VOTE_SOP) begin : g_sop
      always_comb voted = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
   end else begin : g_mux
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_comb voted[i] = (in_a[i] == in_b[i]) ? in_a[i] : in_c[i];
      end
   end
endmodule

// File: rtl/tmr_cnt_lane.sv
module tmr_cnt_lane
   import tmr_cnt_pkg::*;
#(
   parameter int unsigned CNT_W = 2,
   localparam int unsigned ST_W = CNT_W + EDGE_BITS
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            btn,
   input  logic            inj_en,
   input  logic [ST_W-1:0] inj_mask,
   input  logic [ST_W-1:0] voted,
   output logic [ST_W-1:0] raw
);
   logic             stage1_v, stage2_v, pulse;
   logic [CNT_W-1:0] count_v, count_n;
   logic [ST_W-1:0]  next_st, flip;

   assign stage1_v = voted[0];
   assign stage2_v = voted[1];
   assign count_v  = voted[ST_W-1:EDGE_BITS];
   assign pulse    = stage1_v & ~stage2_v;

   always_comb begin
      count_n = count_v;
      if (pulse) count_n = count_v + 1'b1;
      if (rst) next_st = '0;
      else     next_st = {count_n, stage1_v, btn};
   end

   assign flip = inj_en ? inj_mask : '0;

   always_ff @(posedge clk) begin
      raw <= next_st ^ flip;
   end
endmodule

// File: rtl/tmr_mismatch_det.sv
module tmr_mismatch_det #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] raw_a,
   input  logic [W-1:0] raw_b,
   input  logic [W-1:0] raw_c,
   output logic         differ
);
   assign differ = (|(raw_a ^ raw_b)) | (|(raw_b ^ raw_c));
endmodule

// File: rtl/tmr_counter_top.sv
module tmr_counter_top
   import tmr_cnt_pkg::*;
#(
   parameter int unsigned CNT_W      = 2,
   parameter vote_style_e VOTE_STYLE = VOTE_SOP,
   localparam int unsigned ST_W      = CNT_W + EDGE_BITS
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     btn,
   input  logic [N_COPIES-1:0]      inj_en,
   input  logic [N_COPIES*ST_W-1:0] inj_mask,
   output logic [CNT_W-1:0]         cnt_a,
   output logic [CNT_W-1:0]         cnt_b,
   output logic [CNT_W-1:0]         cnt_c,
   output logic                     mismatch
);
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("tmr_counter_top: CNT_W out of range");
   end
   if (N_COPIES != 3) begin : g_bad_copies
      $error("tmr_counter_top: majority voting needs exactly three copies");
   end

   logic [ST_W-1:0] raw_st   [N_COPIES];
   logic [ST_W-1:0] voted_st [N_COPIES];

   for (genvar k = 0; k < N_COPIES; k++) begin : g_copy
      tmr_maj_voter #(.W(ST_W), .STYLE(VOTE_STYLE)) u_vote (
         .in_a  (raw_st[0]),
         .in_b  (raw_st[1]),
         .in_c  (raw_st[2]),
         .voted (voted_st[k])
      );

      tmr_cnt_lane #(.CNT_W(CNT_W)) u_lane (
         .clk      (clk),
         .rst      (rst),
         .btn      (btn),
         .inj_en   (inj_en[k]),
         .inj_mask (inj_mask[k*ST_W +: ST_W]),
         .voted    (voted_st[k]),
         .raw      (raw_st[k])
      );
   end

   assign cnt_a = voted_st[0][ST_W-1:EDGE_BITS];
   assign cnt_b = voted_st[1][ST_W-1:EDGE_BITS];
   assign cnt_c = voted_st[2][ST_W-1:EDGE_BITS];

   tmr_mismatch_det #(.W(ST_W)) u_det (
      .raw_a  (raw_st[0]),
      .raw_b  (raw_st[1]),
      .raw_c  (raw_st[2]),
      .differ (mismatch)
   );
endmodule

// File: rtl/tmr_counter_chk.sv
module tmr_counter_chk #(
   parameter int unsigned CNT_W = 2,
   parameter int unsigned ST_W  = CNT_W + 2
) (
   input logic                 clk,
   input logic                 rst,
   input logic [2:0]           inj_en,
   input logic [3*ST_W-1:0]    inj_mask,
   input logic [CNT_W-1:0]     cnt_a,
   input logic [CNT_W-1:0]     cnt_b,
   input logic [CNT_W-1:0]     cnt_c,
   input logic                 mismatch
);
   logic fault_in;
   always_comb begin
      fault_in = 1'b0;
      for (int k = 0; k < 3; k++)
         if (inj_en[k] && (|inj_mask[k*ST_W +: ST_W])) fault_in = 1'b1;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (cnt_a == '0 && cnt_b == '0 && cnt_c == '0));

   // R5
   copies_agree_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_a == cnt_b) && (cnt_b == cnt_c));

   // R3
   step_one_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((cnt_a == $past(cnt_a)) || (cnt_a == CNT_W'($past(cnt_a) + 1'b1))));

   // R6
   fault_seen_chk: assert property (@(posedge clk)
      fault_in |=> mismatch);

   // R7
   recover_chk: assert property (@(posedge clk)
      (inj_en == 3'b000) |=> !mismatch);
endmodule

bind tmr_counter_top tmr_counter_chk #(.CNT_W(CNT_W), .ST_W(ST_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .inj_en   (inj_en),
   .inj_mask (inj_mask),
   .cnt_a    (cnt_a),
   .cnt_b    (cnt_b),
   .cnt_c    (cnt_c),
   .mismatch (mismatch)
);

// File: tb/tmr_counter_top_tb.sv
module tmr_counter_top_tb;
   localparam int CW = 2;
   localparam int SW = CW + 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          btn = 1'b0;
   logic [2:0]    inj_en = '0;
   logic [3*SW-1:0] inj_mask = '0;
   logic [CW-1:0] cnt_a, cnt_b, cnt_c;
   logic          mismatch;

   int n_tests = 0;
   int n_fail  = 0;

   typedef struct {
      logic [CW-1:0] cnt;
      logic          err;
      string         tag;
   } exp_t;
   exp_t sb_q[$];

   logic          m_b1 = 1'b0, m_b2 = 1'b0;
   logic [CW-1:0] m_cnt = '0;

   always #5 clk = ~clk;

   tmr_counter_top #(.CNT_W(CW)) u_dut (
      .clk(clk), .rst(rst), .btn(btn), .inj_en(inj_en), .inj_mask(inj_mask),
      .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_c(cnt_c), .mismatch(mismatch)
   );

   task automatic step(input logic b, input logic r, input int copy,
                       input logic [SW-1:0] m, input string tag);
      exp_t it;
      logic pulse;
      @(negedge clk);
      btn = b;
      rst = r;
      inj_en = '0;
      inj_mask = '0;
      if (copy >= 0) begin
         inj_en[copy] = 1'b1;
         inj_mask[copy*SW +: SW] = m;
      end
      pulse = m_b1 & ~m_b2;
      if (r) begin
         m_cnt = '0; m_b1 = 1'b0; m_b2 = 1'b0;
      end else begin
         if (pulse) m_cnt = m_cnt + 1'b1;
         m_b2 = m_b1;
         m_b1 = b;
      end
      it.cnt = m_cnt;
      it.err = (copy >= 0) && (m != '0);
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   always @(posedge clk) begin
      #2;
      if (sb_q.size() > 0) begin
         exp_t it;
         it = sb_q.pop_front();
         n_tests++;
         if (cnt_a !== it.cnt || cnt_b !== it.cnt || cnt_c !== it.cnt) begin
            n_fail++;
            $display("FAIL %s count: got %0d/%0d/%0d expected %0d",
                     it.tag, cnt_a, cnt_b, cnt_c, it.cnt);
         end
         n_tests++;
         if (mismatch !== it.err) begin
            n_fail++;
            $display("FAIL %s mismatch: got %0b expected %0b",
                     it.err ? "R6" : "R7", mismatch, it.err);
         end
      end
   end

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) step(1'b0, 1'b1, -1, '0, "R1");
      // R3: single press held high
      step(1'b1, 1'b0, -1, '0, "R3");
      repeat (5) step(1'b1, 1'b0, -1, '0, "R3");
      repeat (2) step(1'b0, 1'b0, -1, '0, "R3");
      // R4: presses up to the wrap
      for (int p = 0; p < 4; p++) begin
         step(1'b1, 1'b0, -1, '0, "R4");
         step(1'b0, 1'b0, -1, '0, "R4");
         step(1'b0, 1'b0, -1, '0, "R4");
      end
      // R2: reset on the edge where the increment lands
      step(1'b1, 1'b0, -1, '0, "R2");
      step(1'b1, 1'b1, -1, '0, "R2");
      step(1'b0, 1'b0, -1, '0, "R2");
      step(1'b0, 1'b0, -1, '0, "R2");
      // R8: enable with empty mask
      for (int c = 0; c < 3; c++) step(1'b0, 1'b0, c, '0, "R8");
      // R5/R6: every mask into every copy, idle then on a press edge
      for (int c = 0; c < 3; c++) begin
         for (int m = 1; m < 16; m++) begin
            step(1'b0, 1'b0, c, SW'(m), "R5");
            step(1'b0, 1'b0, -1, '0, "R7");
            step(1'b1, 1'b0, -1, '0, "R5");
            step(1'b1, 1'b0, c, SW'(m), "R5");
            step(1'b0, 1'b0, -1, '0, "R7");
         end
      end
      // R5: random presses with occasional single-copy faults
      for (int i = 0; i < 400; i++) begin
         logic b;
         b = 1'($urandom_range(0, 1));
         if ($urandom_range(0, 3) == 0)
            step(b, 1'b0, int'($urandom_range(0, 2)), SW'($urandom_range(1, 15)), "R5");
         else
            step(b, 1'b0, -1, '0, "R5");
      end
      step(1'b0, 1'b0, -1, '0, "R7");
      repeat (3) @(posedge clk);
      #3;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule